// File: doc/BRIEF.md
# Programmable Priority Interrupt Resolver

This block picks, for each of two interrupt classes (fast and normal), the single source that software has ranked highest among those currently asserted. Ranking comes from a table of 40 programmable slots. Each slot carries a valid flag and the ID of one source. Slot 0 is the most urgent. The block does not hold pending state, enable masks or class routing. It receives an already-masked active vector and a per-source class vector from the neighbouring steering logic, and it returns one packed result word that holds both winners.

Software programs the slots over a simple register bus: a write strobe, a read strobe, a byte address and 32-bit data. The result word is read at its own address. Read data is registered and appears on the cycle after the read strobe. It reflects the inputs and the table as they stood on the read edge.

Top module: `irq_rank_resolver`

## Requirements
- R1: Slot n for n < 32 sits at byte address 0x1C + 4n. Slot 32 + m, for m from 0 to 7, sits at byte address 0xB0 + 4m. A write to a slot's address changes only that slot.
- R2: A slot stores only bit 31 (valid) and bits 5:0 (source ID). On readback every other bit is 0, so writing 0xFFFFFFE7 reads back as 0x80000027.
- R3: After reset every slot reads 0, and the result word reads 0x003F003F.
- R4: A slot is ignored unless its valid bit is set and its ID is below 40.
- R5: In each class the lowest-numbered qualifying slot wins. The two classes are resolved independently.
- R6: A slot is a fast-class candidate when its source is active and its class bit is 1. It is a normal-class candidate when its source is active and its class bit is 0.
- R7: The result word sits at address 0x18. It has the fast winner ID in bits 5:0, the fast valid flag in bit 15, the normal winner ID in bits 21:16, the normal valid flag in bit 31, and zeros elsewhere.
- R8: A class with no winner reports valid 0 and ID 0x3F.
- R9: The result word is read-only. Writes to 0x18 change nothing.
- R10: When several slots name the same source, the lowest-numbered one decides. The duplicates raise no error and do not disturb the result.
- R11: Read data is registered. It is valid on the cycle after the read strobe and holds the values present at that edge. It reads 0 on the cycle after a cycle with no read.
- R12: A read from an address that is neither a slot nor the result word returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| active_vec | input | 40 | Pending-and-enabled source vector |
| fast_route | input | 40 | Class per source: 1 fast, 0 normal |

## Verification
A fixed slot table is loaded first. It includes an invalid-flag slot, an out-of-range ID, a duplicate source and entries in the upper bank. The bench then walks active and class vectors through it. The patterns are: no source active, a single source in each class, both classes at once with different winners, all sources active, and upper-bank slots competing with each other. Together these separate rank order from source numbering, show that the two classes are resolved independently, and show that unqualified slots are skipped. Directed reads check reset values, the write mask, the read-only result address, unmapped addresses, and that read data is captured at the read edge and is not live.

// File: rtl/irq_rank_resolver.sv
module irq_rank_resolver #(
  parameter int NSRC    = 40,
  parameter int IDW     = 6,
  parameter int AW      = 8,
  parameter int LO_CNT  = 32,
  parameter int RES_OFF = 'h18,
  parameter int LO_BASE = 'h1C,
  parameter int HI_BASE = 'hB0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  input  logic [NSRC-1:0] active_vec,
  input  logic [NSRC-1:0] fast_route
);

  localparam logic [IDW-1:0] NONE_ID = '1;
  localparam logic [IDW-1:0] LIMIT   = IDW'(NSRC);
  localparam int             PAD     = 15 - IDW;

  function automatic logic [AW-1:0] slot_off(input int i);
    return (i < LO_CNT) ? AW'(LO_BASE + 4 * i) : AW'(HI_BASE + 4 * (i - LO_CNT));
  endfunction

  logic           slot_v  [NSRC];
  logic [IDW-1:0] slot_id [NSRC];

  for (genvar g = 0; g < NSRC; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_v[g]  <= 1'b0;
        slot_id[g] <= '0;
      end else if (wr_en && addr == slot_off(g)) begin
        slot_v[g]  <= wdata[31];
        slot_id[g] <= wdata[IDW-1:0];
      end
    end
  end

  logic           fast_v, norm_v;
  logic [IDW-1:0] fast_id, norm_id;

  always_comb begin
    fast_v  = 1'b0;
    norm_v  = 1'b0;
    fast_id = NONE_ID;
    norm_id = NONE_ID;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (slot_v[i] && slot_id[i] < LIMIT && active_vec[slot_id[i]]) begin
        if (fast_route[slot_id[i]]) begin
          fast_v  = 1'b1;
          fast_id = slot_id[i];
        end else begin
          norm_v  = 1'b1;
          norm_id = slot_id[i];
        end
      end
    end
  end

  wire [31:0] result = {norm_v, {PAD{1'b0}}, norm_id, fast_v, {PAD{1'b0}}, fast_id};

  logic [31:0] rd_mux;
  logic        slot_hit;

  always_comb begin
    rd_mux   = '0;
    slot_hit = 1'b0;
    if (addr == AW'(RES_OFF)) rd_mux = result;
    for (int i = 0; i < NSRC; i++) begin
      if (addr == slot_off(i)) begin
        slot_hit = 1'b1;
        rd_mux   = {slot_v[i], {(31-IDW){1'b0}}, slot_id[i]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_en ? rd_mux : '0;
  end

  p_fast_class_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fast_v |-> (fast_id < LIMIT && active_vec[fast_id] && fast_route[fast_id]));

  p_norm_class_r6: assert property (@(posedge clk) disable iff (!rst_n)
    norm_v |-> (norm_id < LIMIT && active_vec[norm_id] && !fast_route[norm_id]));

  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> rdata == 32'h0);

  p_slot_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && slot_hit) |=> rdata[30:IDW] == '0);

  p_no_work_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active_vec == '0) |-> (result == {1'b0, {PAD{1'b0}}, NONE_ID, 1'b0, {PAD{1'b0}}, NONE_ID}));

endmodule

// File: tb/sim_irq_rank_resolver.sv
module sim_irq_rank_resolver;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [39:0] active_vec = '0, fast_route = '0;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  irq_rank_resolver u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .active_vec(active_vec), .fast_route(fast_route));

  // {active, route, expected result}
  localparam int NV = 11;
  localparam logic [111:0] VEC [NV] = '{
    {40'h0,           40'h0,           32'h003F003F},  // R8 none
    {40'h20,          40'h0,           32'h8005003F},  // R6 R7 normal src5
    {40'h20,          40'h20,          32'h003F8005},  // R6 fast src5
    {40'h1020,        40'h1000,        32'h8005800C},  // R5 both classes
    {40'h80_0000_1000,40'h0,           32'h800C003F},  // R5 slot1 over slot2
    {40'h80_0000_0000,40'h80_0000_0000,32'h003F8027},  // R1 masked slot2 id 39
    {40'h80,          40'h0,           32'h003F003F},  // R4 invalid flag slot
    {40'h10_0000,     40'h0,           32'h8014003F},  // R1 upper bank slot32
    {40'h10_0001,     40'h1,           32'h80148000},  // R5 slot32 vs slot39
    {40'h1,           40'h0,           32'h8000003F},  // R1 slot39
    {40'hFF_FFFF_FFFF,40'h0,           32'h8005003F}   // R4 R10 all active
  };

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, rdata, exp);
    end
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R3 reset state
    rd_chk(8'h1C, 32'h0, "R3");
    rd_chk(8'hCC, 32'h0, "R3");
    rd_chk(8'h18, 32'h003F003F, "R3");
    // program table
    wr(8'h1C, 32'h8000_0005);   // slot0 src5
    wr(8'h20, 32'h8000_000C);   // slot1 src12
    wr(8'h24, 32'hFFFF_FFE7);   // slot2 -> src39 valid
    wr(8'h28, 32'h8000_0028);   // slot3 id 40 (out of range)
    wr(8'h2C, 32'h0000_0007);   // slot4 src7 invalid
    wr(8'h30, 32'h8000_0005);   // slot5 duplicate src5
    wr(8'hB0, 32'h8000_0014);   // slot32 src20
    wr(8'hCC, 32'h8000_0000);   // slot39 src0
    rd_chk(8'h24, 32'h8000_0027, "R2");
    rd_chk(8'hB0, 32'h8000_0014, "R1");
    rd_chk(8'hB4, 32'h0, "R1");
    rd_chk(8'h34, 32'h0, "R1");
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      active_vec = VEC[i][111:72];
      fast_route = VEC[i][71:32];
      rd_chk(8'h18, VEC[i][31:0], "R5/R6/R7 vector");
    end
    // R10 duplicate: slot5 src5 changed class still loses to slot0 in same class
    active_vec = 40'h20; fast_route = 40'h0;
    rd_chk(8'h30, 32'h8000_0005, "R10");
    rd_chk(8'h18, 32'h8005003F, "R10");
    // R9 result address is read-only
    wr(8'h18, 32'h1234_5678);
    active_vec = 40'h0;
    rd_chk(8'h18, 32'h003F003F, "R9");
    rd_chk(8'h1C, 32'h8000_0005, "R9");
    // R12 unmapped
    rd_chk(8'h00, 32'h0, "R12");
    rd_chk(8'hD0, 32'h0, "R12");
    // R11 captured at read edge, then zero
    @(negedge clk); active_vec = 40'h1000; rd_en = 1; addr = 8'h18;
    @(negedge clk); rd_en = 0; active_vec = 40'h0;
    checks++;
    if (rdata !== 32'h800C003F) begin
      errors++; $display("FAIL R11 actual=%h expected=%h", rdata, 32'h800C003F);
    end
    @(negedge clk);
    checks++;
    if (rdata !== 32'h0) begin
      errors++; $display("FAIL R11 actual=%h expected=%h", rdata, 32'h0);
    end
    // R3 reset clears table
    rst_n = 0; @(negedge clk); rst_n = 1;
    active_vec = 40'h20;
    rd_chk(8'h18, 32'h003F003F, "R3");
    rd_chk(8'h1C, 32'h0, "R3");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule